// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a bank of general purpose pins behind a plain memory-mapped register bus that has single-cycle write strobes and reads that settle in the same cycle. Each pin input passes through a synchroniser, and software reads the result as the current pin level. Output data and output enable are never written directly. Software changes them through separate write-one-to-set and write-one-to-clear addresses, so one pin can be updated without a read-modify-write sequence.

Every pin has two interrupt enables, one for rising edges and one for falling edges. An enabled edge sets a sticky pending flag for that pin. Software acknowledges a flag by writing a one to its bit. All pending flags are ORed into one level-sensitive interrupt line.

Top module: `gpio_edge_bank`

## Requirements
- R1: Reset clears output data, output enable, both edge enable masks and every pending flag. After reset `pad_out`, `pad_oe` and `irq` are all zero.
- R2: A read of address 0x00 returns the pin levels. A change on `pad_in` becomes visible there after two rising clock edges.
- R3: Writing a mask to 0x14 sets the matching `pad_out` bits, and writing a mask to 0x18 clears them. Bits written as zero keep their value. Reading 0x14 or 0x18 returns the output data.
- R4: Writing a mask to 0x1C sets the matching `pad_oe` bits, and writing a mask to 0x20 clears them. Reading 0x1C or 0x20 returns the output enable.
- R5: A rising edge on a pin whose bit is set in the rising mask sets that pin's pending bit. A rising edge on a pin with the bit clear leaves the pending bit unchanged. The pending register is read at 0x0C, and the flag appears three clock edges after the pin change.
- R6: A falling edge on a pin whose bit is set in the falling mask sets that pin's pending bit.
- R7: A pin enabled in both masks raises its pending bit on either edge direction.
- R8: Writing to 0x0C clears each pending bit written as one. Pending bits written as zero keep their value.
- R9: If an enabled edge is detected in the same cycle as a clear of that pin's bit, the pending bit stays set.
- R10: `irq` is high exactly while at least one pending bit is set, and it stays high until the last one is cleared.
- R11: Addresses outside the map read as zero, and writes to them change no register.
- R12: The rising mask at 0x28 and the falling mask at 0x2C are ordinary read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, valid in the same cycle |
| pad_in | input | NUM_PINS | Asynchronous pin inputs |
| pad_out | output | NUM_PINS | Output data to the pad drivers |
| pad_oe | output | NUM_PINS | Output enable to the pad drivers |
| irq | output | 1 | Level interrupt, OR of the pending flags |

## Verification
A wrong previous-sample register, or a wrong merge of enable and clear, shows up as a missing or extra pending bit and a wrong `irq` level on the third edge after the pin change. The bench therefore samples at exactly that edge. A wrong set/clear merge in the output registers shows on `pad_out` or `pad_oe` on the edge after the write. The collision of a clear with a new edge is driven in the one cycle in which the edge is detected, so an ordering error there leaves the flag cleared.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam logic [7:0] OFS_LEVEL   = 8'h00;
   localparam logic [7:0] OFS_PEND    = 8'h0C;
   localparam logic [7:0] OFS_OUT_SET = 8'h14;
   localparam logic [7:0] OFS_OUT_CLR = 8'h18;
   localparam logic [7:0] OFS_OE_SET  = 8'h1C;
   localparam logic [7:0] OFS_OE_CLR  = 8'h20;
   localparam logic [7:0] OFS_RISE    = 8'h28;
   localparam logic [7:0] OFS_FALL    = 8'h2C;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_LEVEL,
      SEL_PEND,
      SEL_OUT_SET,
      SEL_OUT_CLR,
      SEL_OE_SET,
      SEL_OE_CLR,
      SEL_RISE,
      SEL_FALL
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_LEVEL:   s = SEL_LEVEL;
         OFS_PEND:    s = SEL_PEND;
         OFS_OUT_SET: s = SEL_OUT_SET;
         OFS_OUT_CLR: s = SEL_OUT_CLR;
         OFS_OE_SET:  s = SEL_OE_SET;
         OFS_OE_CLR:  s = SEL_OE_CLR;
         OFS_RISE:    s = SEL_RISE;
         OFS_FALL:    s = SEL_FALL;
         default:     s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] wmask,
   input  logic             out_set,
   input  logic             out_clr,
   input  logic             oe_set,
   input  logic             oe_clr,
   input  logic             rise_wr,
   input  logic             fall_wr,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] oe_q,
   output logic [WIDTH-1:0] rise_q,
   output logic [WIDTH-1:0] fall_q
);
   logic [WIDTH-1:0] out_d, oe_d;

   always_comb begin
      out_d = out_q;
      if (out_set) out_d = out_d | wmask;
      if (out_clr) out_d = out_d & ~wmask;
      oe_d = oe_q;
      if (oe_set) oe_d = oe_d | wmask;
      if (oe_clr) oe_d = oe_d & ~wmask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q  <= '0;
         oe_q   <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         out_q <= out_d;
         oe_q  <= oe_d;
         if (rise_wr) rise_q <= wmask;
         if (fall_wr) fall_q <= wmask;
      end
   end
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic             ack_wr,
   input  logic [WIDTH-1:0] ack_mask,
   output logic [WIDTH-1:0] pend_q
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign hit[i] = (rise_en[i] &  level[i] & ~prev_q[i]) |
                      (fall_en[i] & ~level[i] &  prev_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= level;
         pend_q <= (pend_q & ~(ack_wr ? ack_mask : '0)) | hit;
      end
   end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);
   localparam int EXT_W = ADDR_W + 8;

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_edge_bank: NUM_PINS must be 1..DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpio_edge_bank: ADDR_W too narrow for the map");
   end

   logic [EXT_W-1:0]    addr_ext;
   reg_sel_e            sel;
   logic [NUM_PINS-1:0] wmask;
   logic [NUM_PINS-1:0] level;
   logic [NUM_PINS-1:0] rise_q, fall_q, pend_q;
   logic [NUM_PINS-1:0] rd_pins;

   assign addr_ext = {8'b0, bus_addr};
   assign sel      = (addr_ext[EXT_W-1:8] == '0) ? decode_ofs(addr_ext[7:0]) : SEL_NONE;
   assign wmask    = bus_wdata[NUM_PINS-1:0];

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(level)
   );

   gpio_ctrl_regs #(.WIDTH(NUM_PINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wmask(wmask),
      .out_set(bus_wr && sel == SEL_OUT_SET),
      .out_clr(bus_wr && sel == SEL_OUT_CLR),
      .oe_set (bus_wr && sel == SEL_OE_SET),
      .oe_clr (bus_wr && sel == SEL_OE_CLR),
      .rise_wr(bus_wr && sel == SEL_RISE),
      .fall_wr(bus_wr && sel == SEL_FALL),
      .out_q(pad_out), .oe_q(pad_oe), .rise_q(rise_q), .fall_q(fall_q)
   );

   gpio_edge_capture #(.WIDTH(NUM_PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .level(level),
      .rise_en(rise_q), .fall_en(fall_q),
      .ack_wr(bus_wr && sel == SEL_PEND), .ack_mask(wmask),
      .pend_q(pend_q)
   );

   always_comb begin
      case (sel)
         SEL_LEVEL:               rd_pins = level;
         SEL_PEND:                rd_pins = pend_q;
         SEL_OUT_SET, SEL_OUT_CLR: rd_pins = pad_out;
         SEL_OE_SET, SEL_OE_CLR:  rd_pins = pad_oe;
         SEL_RISE:                rd_pins = rise_q;
         SEL_FALL:                rd_pins = fall_q;
         default:                 rd_pins = '0;
      endcase
   end

   assign bus_rdata = DATA_W'(rd_pins);
   assign irq       = |pend_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                irq,
   input logic [NUM_PINS-1:0] rise_q,
   input logic [NUM_PINS-1:0] fall_q,
   input logic [NUM_PINS-1:0] pend_q
);
   logic [NUM_PINS-1:0] m;
   logic w_oset, w_oclr, w_eset, w_eclr, w_pend, w_map;
   assign m      = bus_wdata[NUM_PINS-1:0];
   assign w_oset = bus_wr && bus_addr == ADDR_W'(OFS_OUT_SET);
   assign w_oclr = bus_wr && bus_addr == ADDR_W'(OFS_OUT_CLR);
   assign w_eset = bus_wr && bus_addr == ADDR_W'(OFS_OE_SET);
   assign w_eclr = bus_wr && bus_addr == ADDR_W'(OFS_OE_CLR);
   assign w_pend = bus_wr && bus_addr == ADDR_W'(OFS_PEND);
   assign w_map  = w_oset || w_oclr || w_eset || w_eclr ||
                   bus_addr == ADDR_W'(OFS_RISE) || bus_addr == ADDR_W'(OFS_FALL) ||
                   bus_addr == ADDR_W'(OFS_PEND);

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (pad_out == '0 && pad_oe == '0 && irq == 1'b0));

   p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      w_oset |=> ((pad_out & $past(m)) == $past(m)));

   p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      w_oclr |=> ((pad_out & $past(m)) == '0));

   p_oe_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      w_eset |=> ((pad_oe & $past(m)) == $past(m)));

   p_oe_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      w_eclr |=> ((pad_oe & $past(m)) == '0));

   p_no_enable_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_q == '0 && fall_q == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

   p_irq_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !w_pend) |=> irq);

   p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !w_map) |=> ($stable(pad_out) && $stable(pad_oe) &&
                              $stable(rise_q) && $stable(fall_q)));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
   .rise_q(rise_q), .fall_q(fall_q), .pend_q(pend_q)
);

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;
   localparam int NP = 32;
   localparam int NV = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic          irq;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   gpio_edge_bank u_gpio_edge_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // {req id, is_write, addr, data, expected read}
   localparam logic [76:0] VEC [NV] = '{
      {4'd3,  1'b1, 8'h14, 32'h0000_00F0, 32'h0},            // R3 set
      {4'd3,  1'b0, 8'h14, 32'h0,         32'h0000_00F0},
      {4'd3,  1'b1, 8'h18, 32'h0000_0030, 32'h0},            // R3 clear
      {4'd3,  1'b0, 8'h18, 32'h0,         32'h0000_00C0},
      {4'd4,  1'b1, 8'h1C, 32'h0000_FF00, 32'h0},            // R4 set
      {4'd4,  1'b0, 8'h1C, 32'h0,         32'h0000_FF00},
      {4'd4,  1'b1, 8'h20, 32'h0000_0F00, 32'h0},            // R4 clear
      {4'd4,  1'b0, 8'h20, 32'h0,         32'h0000_F000},
      {4'd12, 1'b1, 8'h28, 32'hA5A5_0001, 32'h0},            // R12 rise mask
      {4'd12, 1'b0, 8'h28, 32'h0,         32'hA5A5_0001},
      {4'd12, 1'b1, 8'h2C, 32'h0000_0003, 32'h0},            // R12 fall mask
      {4'd12, 1'b0, 8'h2C, 32'h0,         32'h0000_0003},
      {4'd11, 1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},            // R11 unmapped
      {4'd11, 1'b0, 8'h04, 32'h0,         32'h0},
      {4'd11, 1'b0, 8'h14, 32'h0,         32'h0000_00C0},
      {4'd11, 1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0},
      {4'd11, 1'b0, 8'h28, 32'h0,         32'hA5A5_0001}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick(1);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      check("R1 pad_out", pad_out, '0);
      check("R1 pad_oe", pad_oe, '0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      rd("R1 pending", 8'h0C, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
         else rd($sformatf("R%0d vec%0d", VEC[i][76:73], i), VEC[i][71:64], VEC[i][31:0]);
      end
      check("R3 pad_out port", pad_out, 32'h0000_00C0);
      check("R4 pad_oe port", pad_oe, 32'h0000_F000);

      wr(8'h28, 32'h1);
      wr(8'h2C, 32'h2);
      // R2 synchroniser latency
      pad_in = 32'h8000_0004;
      tick(1);
      rd("R2 one edge", 8'h00, 32'h0);
      tick(1);
      rd("R2 two edges", 8'h00, 32'h8000_0004);
      tick(2);
      rd("R5 disabled rise", 8'h0C, 32'h0);
      // R5 enabled rise on pin 0
      pad_in[0] = 1'b1;
      tick(2);
      rd("R5 not yet", 8'h0C, 32'h0);
      tick(1);
      rd("R5 pending", 8'h0C, 32'h1);
      check("R10 irq set", {31'b0, irq}, 32'h1);
      // R6 falling on pin 1
      pad_in[1] = 1'b1;
      tick(3);
      rd("R6 rise ignored", 8'h0C, 32'h1);
      pad_in[1] = 1'b0;
      tick(3);
      rd("R6 pending", 8'h0C, 32'h3);
      // R8 / R10 acknowledge
      wr(8'h0C, 32'h1);
      rd("R8 partial clear", 8'h0C, 32'h2);
      check("R10 irq held", {31'b0, irq}, 32'h1);
      wr(8'h0C, 32'h2);
      rd("R8 full clear", 8'h0C, 32'h0);
      check("R10 irq low", {31'b0, irq}, 32'h0);
      // R7 both edges on pin 4
      wr(8'h28, 32'h10);
      wr(8'h2C, 32'h10);
      pad_in[4] = 1'b1;
      tick(3);
      rd("R7 rise", 8'h0C, 32'h10);
      wr(8'h0C, 32'h10);
      pad_in[4] = 1'b0;
      tick(3);
      rd("R7 fall", 8'h0C, 32'h10);
      wr(8'h0C, 32'h10);
      // R9 clear colliding with new edge on pin 0 (currently high)
      wr(8'h28, 32'h1);
      wr(8'h2C, 32'h0);
      pad_in[0] = 1'b0;
      tick(3);
      pad_in[0] = 1'b1;
      tick(3);
      rd("R9 setup", 8'h0C, 32'h1);
      pad_in[0] = 1'b0;
      tick(3);
      pad_in[0] = 1'b1;
      tick(2);
      wr(8'h0C, 32'h1);
      rd("R9 collision keeps flag", 8'h0C, 32'h1);
      wr(8'h0C, 32'h1);
      rd("R9 later clear", 8'h0C, 32'h0);
      // R1 reset mid-run
      wr(8'h14, 32'hFFFF_FFFF);
      pad_in[0] = 1'b0;
      tick(1);
      pad_in[0] = 1'b1;
      tick(2);
      rst_n = 1'b0;
      tick(1);
      rst_n = 1'b1;
      check("R1 reapplied pad_out", pad_out, '0);
      check("R1 reapplied irq", {31'b0, irq}, 32'h0);
      rd("R1 reapplied rise", 8'h28, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule